// File: doc/BRIEF.md
# Serial Diagnostic Loopback Router

This block sits between a serial transmitter/receiver pair and the line and modem pins of a serial port. A two-bit mode input chooses one of three routings: normal operation, a local loop in which the transmitter's own output and clock feed the receiver, and a remote loop in which every character the receiver assembles is handed back to the transmitter and sent out again. The block picks the receiver's serial source and bit-clock enable and the transmitter's bit-clock enable. It drives the TxD, DTR and RTS pins and the modem status seen by the core. It also gates the effective enable bits and the active-low ready pins seen by the host.

The block owns the transmit holding register. In normal and local operation the host writes it. In remote operation received characters load it, and host writes are dropped. The transmitter drains it through a take strobe. The mode is registered, so a new mode value acts from the following clock edge.

Two state machines are involved. The mode machine has states NORMAL, LOCAL and REMOTE. Its transitions are ENTER_NORMAL (mode 00 or 01), ENTER_LOCAL (mode 10) and ENTER_REMOTE (mode 11), and any of them can be taken from any state on any edge. The holding machine has states EMPTY and FULL. Its transitions are FILL (EMPTY to FULL on a load), DRAIN (FULL to EMPTY on a take with no load), REFILL (FULL stays FULL when load and take coincide) and OVERWRITE (FULL stays FULL on a load without a take).

Top module: `loopback_router`

## Requirements
- R1: Mode code 00 and 01 select normal, 10 selects local loop, 11 selects remote loop. The routing follows the mode sampled at the latest rising clock edge, and while reset is held the routing is normal.
- R2: In local loop, rcv_serial equals tx_serial and rcv_clk_en equals tx_clk_en. xmt_clk_en equals tx_clk_en, and pin_txd, pin_dtr_n and pin_rts_n are all 1.
- R3: In local loop, sts_dcd equals ctl_dtr, sts_cts equals ctl_rts and sts_dsr is 0. The pins pin_rxd, pin_cts_n, pin_dcd_n and pin_dsr_n have no effect on any output.
- R4: In local loop, tx_en_eff and rx_en_eff both equal ctl_tx_en AND ctl_dtr AND ctl_rts, and ctl_rx_en has no effect.
- R5: In normal mode, rcv_serial equals pin_rxd, rcv_clk_en equals rx_clk_en, xmt_clk_en equals tx_clk_en and pin_txd equals tx_serial. pin_dtr_n is NOT ctl_dtr and pin_rts_n is NOT ctl_rts. Each sts_* output is the inverse of its active-low pin, and tx_en_eff and rx_en_eff equal ctl_tx_en and ctl_rx_en.
- R6: In remote loop, xmt_clk_en equals rx_clk_en, rcv_clk_en equals rx_clk_en, rcv_serial equals pin_rxd and pin_txd equals tx_serial. tx_en_eff is 1 whatever ctl_tx_en is, rx_en_eff equals ctl_rx_en, and the modem pins and status behave as in normal mode.
- R7: In remote loop, cpu_rx_valid is 0 and rx_char_valid loads rx_char into the holding register, while cpu_tx_wr is ignored. In the other modes cpu_rx_valid follows rx_char_valid, cpu_tx_wr loads cpu_tx_data, and rx_char_valid loads nothing. cpu_rx_data always equals rx_char.
- R8: err_par equals rx_par_err and err_frm equals rx_frm_err in every mode.
- R9: In remote loop, rxrdy_n, txrdy_n and txemt_n are all 1. Otherwise each is the inverse of core_rxrdy, core_txrdy and core_txemt respectively.
- R10: A load makes xmt_valid 1 with xmt_data equal to the loaded value after the next edge. A take with no load clears xmt_valid after the edge. A load together with a take leaves xmt_valid 1 holding the new value, and xmt_valid is 0 after reset.
- R11: In remote loop, a load while xmt_valid is 1 and xmt_take is 0 replaces xmt_data and sets echo_ovr after that edge. echo_ovr stays set while the mode stays remote and clears on the first edge at which the mode is not 11. A host overwrite in normal mode never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Diagnostic mode code |
| ctl_tx_en | input | 1 | Host transmit-enable bit |
| ctl_rx_en | input | 1 | Host receive-enable bit |
| ctl_dtr | input | 1 | Host data-terminal-ready request |
| ctl_rts | input | 1 | Host request-to-send bit |
| tx_serial | input | 1 | Transmitter serial output |
| tx_clk_en | input | 1 | Transmit bit-clock enable |
| rx_clk_en | input | 1 | Receive bit-clock enable |
| pin_rxd | input | 1 | Line receive data |
| pin_cts_n | input | 1 | Clear-to-send pin, active low |
| pin_dcd_n | input | 1 | Carrier-detect pin, active low |
| pin_dsr_n | input | 1 | Data-set-ready pin, active low |
| pin_txd | output | 1 | Line transmit data |
| pin_dtr_n | output | 1 | Data-terminal-ready pin, active low |
| pin_rts_n | output | 1 | Request-to-send pin, active low |
| rcv_serial | output | 1 | Serial input to the receiver |
| rcv_clk_en | output | 1 | Bit-clock enable to the receiver |
| xmt_clk_en | output | 1 | Bit-clock enable to the transmitter |
| sts_cts | output | 1 | Clear-to-send seen by the core |
| sts_dcd | output | 1 | Carrier-detect seen by the core |
| sts_dsr | output | 1 | Data-set-ready seen by the core |
| tx_en_eff | output | 1 | Effective transmit enable |
| rx_en_eff | output | 1 | Effective receive enable |
| core_rxrdy | input | 1 | Core receive-ready status |
| core_txrdy | input | 1 | Core transmit-ready status |
| core_txemt | input | 1 | Core transmitter-empty or modem-change status |
| rxrdy_n | output | 1 | Receive-ready pin, active low |
| txrdy_n | output | 1 | Transmit-ready pin, active low |
| txemt_n | output | 1 | Transmitter-empty pin, active low |
| rx_par_err | input | 1 | Receiver parity error flag |
| rx_frm_err | input | 1 | Receiver framing error flag |
| err_par | output | 1 | Parity error to host status |
| err_frm | output | 1 | Framing error to host status |
| rx_char_valid | input | 1 | Receiver finished a character |
| rx_char | input | DATA_W | Received character |
| cpu_rx_valid | output | 1 | Character offered to the host |
| cpu_rx_data | output | DATA_W | Character data to the host |
| cpu_tx_wr | input | 1 | Host write to the holding register |
| cpu_tx_data | input | DATA_W | Host write data |
| xmt_take | input | 1 | Transmitter moves holding register into its shifter |
| xmt_valid | output | 1 | Holding register full |
| xmt_data | output | DATA_W | Holding register contents |
| echo_ovr | output | 1 | Remote-loop overwrite flag |

## Verification
A wrong mode state shows as a wrong pin level on the edge after the mode input changes. The clearest signs are pin_txd following tx_serial in local loop, or the ready pins going low in remote loop, so a routing fault is visible within one cycle of the mode edge. A holding machine stuck in the wrong state shows as xmt_valid or xmt_data disagreeing with the load and take history one edge after the offending strobe. A lost overrun bit shows as echo_ovr failing to rise on the edge of the second uncollected character. The bench therefore sweeps every static input combination in every mode code, and drives the holding register through each of its transitions with a check after every edge.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic [1:0] {
        LB_NORMAL = 2'd0,
        LB_LOCAL  = 2'd1,
        LB_REMOTE = 2'd2
    } lb_state_e;

    typedef enum logic {
        HR_EMPTY = 1'b0,
        HR_FULL  = 1'b1
    } hr_state_e;

    localparam logic [1:0] MODE_NORMAL   = 2'b00;
    localparam logic [1:0] MODE_RESERVED = 2'b01;
    localparam logic [1:0] MODE_LOCAL    = 2'b10;
    localparam logic [1:0] MODE_REMOTE   = 2'b11;

endpackage

// File: rtl/lb_mode_fsm.sv
module lb_mode_fsm
    import lb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    output logic       is_local,
    output logic       is_remote
);

    lb_state_e state_q;
    lb_state_e state_d;

    // transition select: ENTER_NORMAL / ENTER_LOCAL / ENTER_REMOTE
    always_comb begin
        state_d = LB_NORMAL;
        unique case (mode)
            MODE_NORMAL, MODE_RESERVED: state_d = LB_NORMAL;
            MODE_LOCAL:                 state_d = LB_LOCAL;
            MODE_REMOTE:                state_d = LB_REMOTE;
            default:                    state_d = LB_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LB_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        is_local  = 1'b0;
        is_remote = 1'b0;
        unique case (state_q)
            LB_NORMAL: ;
            LB_LOCAL:  is_local  = 1'b1;
            LB_REMOTE: is_remote = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/lb_pin_router.sv
module lb_pin_router (
    input  logic is_local,
    input  logic is_remote,
    input  logic ctl_tx_en,
    input  logic ctl_rx_en,
    input  logic ctl_dtr,
    input  logic ctl_rts,
    input  logic tx_serial,
    input  logic tx_clk_en,
    input  logic rx_clk_en,
    input  logic pin_rxd,
    input  logic pin_cts_n,
    input  logic pin_dcd_n,
    input  logic pin_dsr_n,
    input  logic core_rxrdy,
    input  logic core_txrdy,
    input  logic core_txemt,
    output logic pin_txd,
    output logic pin_dtr_n,
    output logic pin_rts_n,
    output logic rcv_serial,
    output logic rcv_clk_en,
    output logic xmt_clk_en,
    output logic sts_cts,
    output logic sts_dcd,
    output logic sts_dsr,
    output logic tx_en_eff,
    output logic rx_en_eff,
    output logic rxrdy_n,
    output logic txrdy_n,
    output logic txemt_n
);

    logic loop_ok;

    always_comb begin
        loop_ok = ctl_tx_en & ctl_dtr & ctl_rts;

        // normal routing first, then mode overrides
        rcv_serial = pin_rxd;
        rcv_clk_en = rx_clk_en;
        xmt_clk_en = tx_clk_en;
        pin_txd    = tx_serial;
        pin_dtr_n  = ~ctl_dtr;
        pin_rts_n  = ~ctl_rts;
        sts_cts    = ~pin_cts_n;
        sts_dcd    = ~pin_dcd_n;
        sts_dsr    = ~pin_dsr_n;
        tx_en_eff  = ctl_tx_en;
        rx_en_eff  = ctl_rx_en;
        rxrdy_n    = ~core_rxrdy;
        txrdy_n    = ~core_txrdy;
        txemt_n    = ~core_txemt;

        if (is_local) begin
            rcv_serial = tx_serial;
            rcv_clk_en = tx_clk_en;
            pin_txd    = 1'b1;
            pin_dtr_n  = 1'b1;
            pin_rts_n  = 1'b1;
            sts_cts    = ctl_rts;
            sts_dcd    = ctl_dtr;
            sts_dsr    = 1'b0;
            tx_en_eff  = loop_ok;
            rx_en_eff  = loop_ok;
        end

        if (is_remote) begin
            xmt_clk_en = rx_clk_en;
            tx_en_eff  = 1'b1;
            rxrdy_n    = 1'b1;
            txrdy_n    = 1'b1;
            txemt_n    = 1'b1;
        end
    end

endmodule

// File: rtl/lb_hold_reg.sv
module lb_hold_reg
    import lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_remote_next,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              ovr
);

    hr_state_e          state_q;
    hr_state_e          state_d;
    logic [DATA_W-1:0]  data_q;
    logic               ovr_q;
    logic               ovr_d;

    // FILL / DRAIN / REFILL / OVERWRITE
    always_comb begin
        state_d = state_q;
        ovr_d   = ovr_q;
        unique case (state_q)
            HR_EMPTY: begin
                if (load) state_d = HR_FULL;
            end
            HR_FULL: begin
                if (take && !load) state_d = HR_EMPTY;
                if (load && !take) ovr_d = 1'b1;
            end
            default: state_d = HR_EMPTY;
        endcase
        if (!is_remote_next) ovr_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HR_EMPTY;
            data_q  <= '0;
            ovr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            ovr_q   <= ovr_d;
            if (load) data_q <= load_data;
        end
    end

    always_comb begin
        full = 1'b0;
        unique case (state_q)
            HR_EMPTY: full = 1'b0;
            HR_FULL:  full = 1'b1;
            default:  full = 1'b0;
        endcase
        data = data_q;
        ovr  = ovr_q;
    end

endmodule

// File: rtl/loopback_router.sv
module loopback_router
    import lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              ctl_tx_en,
    input  logic              ctl_rx_en,
    input  logic              ctl_dtr,
    input  logic              ctl_rts,
    input  logic              tx_serial,
    input  logic              tx_clk_en,
    input  logic              rx_clk_en,
    input  logic              pin_rxd,
    input  logic              pin_cts_n,
    input  logic              pin_dcd_n,
    input  logic              pin_dsr_n,
    output logic              pin_txd,
    output logic              pin_dtr_n,
    output logic              pin_rts_n,
    output logic              rcv_serial,
    output logic              rcv_clk_en,
    output logic              xmt_clk_en,
    output logic              sts_cts,
    output logic              sts_dcd,
    output logic              sts_dsr,
    output logic              tx_en_eff,
    output logic              rx_en_eff,
    input  logic              core_rxrdy,
    input  logic              core_txrdy,
    input  logic              core_txemt,
    output logic              rxrdy_n,
    output logic              txrdy_n,
    output logic              txemt_n,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    output logic              err_par,
    output logic              err_frm,
    input  logic              rx_char_valid,
    input  logic [DATA_W-1:0] rx_char,
    output logic              cpu_rx_valid,
    output logic [DATA_W-1:0] cpu_rx_data,
    input  logic              cpu_tx_wr,
    input  logic [DATA_W-1:0] cpu_tx_data,
    input  logic              xmt_take,
    output logic              xmt_valid,
    output logic [DATA_W-1:0] xmt_data,
    output logic              echo_ovr
);

    logic              is_local;
    logic              is_remote;
    logic              is_remote_next;
    logic              thr_load;
    logic [DATA_W-1:0] thr_src;

    lb_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .is_local  (is_local),
        .is_remote (is_remote)
    );

    lb_pin_router u_route (
        .is_local   (is_local),
        .is_remote  (is_remote),
        .ctl_tx_en  (ctl_tx_en),
        .ctl_rx_en  (ctl_rx_en),
        .ctl_dtr    (ctl_dtr),
        .ctl_rts    (ctl_rts),
        .tx_serial  (tx_serial),
        .tx_clk_en  (tx_clk_en),
        .rx_clk_en  (rx_clk_en),
        .pin_rxd    (pin_rxd),
        .pin_cts_n  (pin_cts_n),
        .pin_dcd_n  (pin_dcd_n),
        .pin_dsr_n  (pin_dsr_n),
        .core_rxrdy (core_rxrdy),
        .core_txrdy (core_txrdy),
        .core_txemt (core_txemt),
        .pin_txd    (pin_txd),
        .pin_dtr_n  (pin_dtr_n),
        .pin_rts_n  (pin_rts_n),
        .rcv_serial (rcv_serial),
        .rcv_clk_en (rcv_clk_en),
        .xmt_clk_en (xmt_clk_en),
        .sts_cts    (sts_cts),
        .sts_dcd    (sts_dcd),
        .sts_dsr    (sts_dsr),
        .tx_en_eff  (tx_en_eff),
        .rx_en_eff  (rx_en_eff),
        .rxrdy_n    (rxrdy_n),
        .txrdy_n    (txrdy_n),
        .txemt_n    (txemt_n)
    );

    // holding-register source selection follows the current mode state
    always_comb begin
        is_remote_next = (mode == MODE_REMOTE);
        if (is_remote) begin
            thr_load = rx_char_valid;
            thr_src  = rx_char;
        end else begin
            thr_load = cpu_tx_wr;
            thr_src  = cpu_tx_data;
        end
        cpu_rx_valid = rx_char_valid & ~is_remote;
        cpu_rx_data  = rx_char;
        err_par      = rx_par_err;
        err_frm      = rx_frm_err;
    end

    lb_hold_reg #(.DATA_W(DATA_W)) u_hold (
        .clk            (clk),
        .rst_n          (rst_n),
        .is_remote_next (is_remote_next),
        .load           (thr_load),
        .load_data      (thr_src),
        .take           (xmt_take),
        .full           (xmt_valid),
        .data           (xmt_data),
        .ovr            (echo_ovr)
    );

endmodule

// File: rtl/loopback_router_chk.sv
module loopback_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       tx_serial,
    input logic       pin_txd,
    input logic       pin_dtr_n,
    input logic       pin_rts_n,
    input logic       rcv_serial,
    input logic       rxrdy_n,
    input logic       txrdy_n,
    input logic       txemt_n,
    input logic       cpu_rx_valid,
    input logic       thr_load,
    input logic       xmt_valid,
    input logic       echo_ovr
);

    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r1_normal_txd: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode) == 2'b00) |-> (pin_txd == tx_serial));

    a_r2_local_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode) == 2'b10) |->
            (pin_txd && pin_dtr_n && pin_rts_n && rcv_serial == tx_serial));

    a_r9_remote_ready_high: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode) == 2'b11) |-> (rxrdy_n && txrdy_n && txemt_n));

    a_r7_remote_no_host_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(mode) == 2'b11) |-> !cpu_rx_valid);

    a_r10_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        thr_load |=> xmt_valid);

    a_r11_ovr_only_remote: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && echo_ovr) |-> ($past(mode) == 2'b11));

endmodule

bind loopback_router loopback_router_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .tx_serial    (tx_serial),
    .pin_txd      (pin_txd),
    .pin_dtr_n    (pin_dtr_n),
    .pin_rts_n    (pin_rts_n),
    .rcv_serial   (rcv_serial),
    .rxrdy_n      (rxrdy_n),
    .txrdy_n      (txrdy_n),
    .txemt_n      (txemt_n),
    .cpu_rx_valid (cpu_rx_valid),
    .thr_load     (thr_load),
    .xmt_valid    (xmt_valid),
    .echo_ovr     (echo_ovr)
);

// File: tb/test_loopback_router.sv
module test_loopback_router;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic ctl_tx_en = 0, ctl_rx_en = 0, ctl_dtr = 0, ctl_rts = 0;
    logic tx_serial = 0, tx_clk_en = 0, rx_clk_en = 0;
    logic pin_rxd = 0, pin_cts_n = 1, pin_dcd_n = 1, pin_dsr_n = 1;
    logic core_rxrdy = 0, core_txrdy = 0, core_txemt = 0;
    logic rx_par_err = 0, rx_frm_err = 0;
    logic rx_char_valid = 0;
    logic [DATA_W-1:0] rx_char = '0;
    logic cpu_tx_wr = 0;
    logic [DATA_W-1:0] cpu_tx_data = '0;
    logic xmt_take = 0;

    logic pin_txd, pin_dtr_n, pin_rts_n, rcv_serial, rcv_clk_en, xmt_clk_en;
    logic sts_cts, sts_dcd, sts_dsr, tx_en_eff, rx_en_eff;
    logic rxrdy_n, txrdy_n, txemt_n, err_par, err_frm;
    logic cpu_rx_valid, xmt_valid, echo_ovr;
    logic [DATA_W-1:0] cpu_rx_data, xmt_data;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    loopback_router #(.DATA_W(DATA_W)) i_loopback_router (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .ctl_tx_en(ctl_tx_en), .ctl_rx_en(ctl_rx_en), .ctl_dtr(ctl_dtr), .ctl_rts(ctl_rts),
        .tx_serial(tx_serial), .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en),
        .pin_rxd(pin_rxd), .pin_cts_n(pin_cts_n), .pin_dcd_n(pin_dcd_n), .pin_dsr_n(pin_dsr_n),
        .pin_txd(pin_txd), .pin_dtr_n(pin_dtr_n), .pin_rts_n(pin_rts_n),
        .rcv_serial(rcv_serial), .rcv_clk_en(rcv_clk_en), .xmt_clk_en(xmt_clk_en),
        .sts_cts(sts_cts), .sts_dcd(sts_dcd), .sts_dsr(sts_dsr),
        .tx_en_eff(tx_en_eff), .rx_en_eff(rx_en_eff),
        .core_rxrdy(core_rxrdy), .core_txrdy(core_txrdy), .core_txemt(core_txemt),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n), .txemt_n(txemt_n),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .err_par(err_par), .err_frm(err_frm),
        .rx_char_valid(rx_char_valid), .rx_char(rx_char),
        .cpu_rx_valid(cpu_rx_valid), .cpu_rx_data(cpu_rx_data),
        .cpu_tx_wr(cpu_tx_wr), .cpu_tx_data(cpu_tx_data),
        .xmt_take(xmt_take), .xmt_valid(xmt_valid), .xmt_data(xmt_data),
        .echo_ovr(echo_ovr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode = m;
        @(posedge clk);
        #1;
    endtask

    task automatic step;
        @(posedge clk);
        #1;
    endtask

    // static sweep of every combination of the routing inputs in one mode code
    task automatic sweep(input logic [1:0] m);
        logic [2:0] e_path, a_path;
        logic [4:0] e_mdm, a_mdm;
        logic [1:0] e_en, a_en;
        logic [2:0] e_rdy, a_rdy;
        logic       loc, rem, ok;
        loc = (m == 2'b10);
        rem = (m == 2'b11);
        for (int v = 0; v < 32768; v++) begin
            {rx_par_err, core_txemt, core_txrdy, core_rxrdy, ctl_rts, ctl_dtr,
             ctl_rx_en, ctl_tx_en, rx_clk_en, tx_clk_en, pin_dsr_n, pin_dcd_n,
             pin_cts_n, pin_rxd, tx_serial} = 15'(v);
            rx_frm_err = rx_par_err ^ tx_serial;
            #1;
            ok = ctl_tx_en & ctl_dtr & ctl_rts;
            // path: rcv_serial, rcv_clk_en, xmt_clk_en, pin_txd
            e_path = loc ? {tx_serial, tx_clk_en, tx_clk_en}
                         : {pin_rxd, rx_clk_en, rem ? rx_clk_en : tx_clk_en};
            a_path = {rcv_serial, rcv_clk_en, xmt_clk_en};
            chk(loc ? "R2 local path" : rem ? "R6 remote path" : "R5 normal path",
                16'({a_path, pin_txd}), 16'({e_path, loc ? 1'b1 : tx_serial}));
            e_mdm = loc ? {1'b1, 1'b1, ctl_rts, ctl_dtr, 1'b0}
                        : {~ctl_dtr, ~ctl_rts, ~pin_cts_n, ~pin_dcd_n, ~pin_dsr_n};
            a_mdm = {pin_dtr_n, pin_rts_n, sts_cts, sts_dcd, sts_dsr};
            chk(loc ? "R3 local modem" : rem ? "R6 remote modem" : "R5 normal modem",
                16'(a_mdm), 16'(e_mdm));
            e_en = loc ? {ok, ok} : rem ? {1'b1, ctl_rx_en} : {ctl_tx_en, ctl_rx_en};
            a_en = {tx_en_eff, rx_en_eff};
            chk(loc ? "R4 local enables" : rem ? "R6 remote enables" : "R5 normal enables",
                16'(a_en), 16'(e_en));
            e_rdy = rem ? 3'b111 : ~{core_rxrdy, core_txrdy, core_txemt};
            a_rdy = {rxrdy_n, txrdy_n, txemt_n};
            chk("R9 ready pins", 16'(a_rdy), 16'(e_rdy));
            chk("R8 error flags", 16'({err_par, err_frm}), 16'({rx_par_err, rx_frm_err}));
        end
        @(negedge clk);
    endtask

    initial begin
        // reset state (R1, R10)
        mode = 2'b10;
        tx_serial = 1'b0;
        #(CLK_PERIOD*2 + 2);
        chk("R1 reset routes normal", 16'(pin_txd), 16'(0));
        chk("R10 reset empty", 16'({xmt_valid, echo_ovr}), 16'(0));
        @(negedge clk);
        mode = 2'b00;
        rst_n = 1'b1;
        step();

        // R1: mode takes effect only at the next edge
        @(negedge clk);
        tx_serial = 1'b0;
        mode = 2'b10;
        #1;
        chk("R1 before edge", 16'(pin_txd), 16'(0));
        @(posedge clk); #1;
        chk("R1 after edge", 16'(pin_txd), 16'(1));
        @(negedge clk);
        mode = 2'b11;
        #1;
        chk("R1 before edge remote", 16'(rxrdy_n), 16'(1));
        @(posedge clk); #1;
        chk("R1 after edge remote", 16'({rxrdy_n, txrdy_n}), 16'(2'b11));

        // exhaustive static sweeps in every mode code (R1..R6, R8, R9)
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            sweep(2'(m));
        end

        // holding register in normal mode (R7, R10, R11)
        set_mode(2'b00);
        @(negedge clk);
        rx_char_valid = 1'b1; rx_char = 8'h3C;
        #1;
        chk("R7 normal host rx valid", 16'({cpu_rx_valid, cpu_rx_data}), 16'({1'b1, 8'h3C}));
        step();
        chk("R7 normal rx does not load", 16'(xmt_valid), 16'(0));
        @(negedge clk);
        rx_char_valid = 1'b0;
        cpu_tx_wr = 1'b1; cpu_tx_data = 8'hA1;
        step();
        chk("R10 fill", 16'({xmt_valid, xmt_data}), 16'({1'b1, 8'hA1}));
        @(negedge clk);
        cpu_tx_data = 8'hB2;
        step();
        chk("R10 overwrite data", 16'({xmt_valid, xmt_data}), 16'({1'b1, 8'hB2}));
        chk("R11 no overrun in normal", 16'(echo_ovr), 16'(0));
        @(negedge clk);
        cpu_tx_data = 8'hC3; xmt_take = 1'b1;
        step();
        chk("R10 refill", 16'({xmt_valid, xmt_data}), 16'({1'b1, 8'hC3}));
        @(negedge clk);
        cpu_tx_wr = 1'b0;
        step();
        chk("R10 drain", 16'(xmt_valid), 16'(0));
        @(negedge clk);
        xmt_take = 1'b0;

        // remote loop echo (R7, R10, R11)
        set_mode(2'b11);
        @(negedge clk);
        cpu_tx_wr = 1'b1; cpu_tx_data = 8'h55;
        step();
        chk("R7 remote host write ignored", 16'(xmt_valid), 16'(0));
        @(negedge clk);
        cpu_tx_wr = 1'b0;
        rx_char_valid = 1'b1; rx_char = 8'h5A;
        #1;
        chk("R7 remote host rx hidden", 16'(cpu_rx_valid), 16'(0));
        step();
        chk("R7 remote echo load", 16'({xmt_valid, xmt_data, echo_ovr}), 16'({1'b1, 8'h5A, 1'b0}));
        @(negedge clk);
        rx_char = 8'h6B; xmt_take = 1'b1;
        step();
        chk("R11 refill no overrun", 16'({xmt_data, echo_ovr}), 16'({8'h6B, 1'b0}));
        @(negedge clk);
        rx_char = 8'h7C; xmt_take = 1'b0;
        step();
        chk("R11 overwrite sets overrun", 16'({xmt_valid, xmt_data, echo_ovr}), 16'({1'b1, 8'h7C, 1'b1}));
        @(negedge clk);
        rx_char_valid = 1'b0; xmt_take = 1'b1;
        step();
        chk("R11 overrun held after drain", 16'({xmt_valid, echo_ovr}), 16'({1'b0, 1'b1}));
        @(negedge clk);
        xmt_take = 1'b0;
        set_mode(2'b01);
        chk("R11 overrun cleared on leaving", 16'(echo_ovr), 16'(0));

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule